// File: doc/BRIEF.md
# Privileged Feature Trap Decision Unit

This block holds a 64-bit control word that belongs to the most privileged of four levels (0 to 3). Beside it, combinational logic decides, for each classified access presented by the decoder, whether that access must be diverted to level 3 and which exception-class code and syndrome detail go with it. The decoder supplies the current level, whether the core runs in 32-bit or 64-bit state, an access class, a per-class qualifier, a flag saying that a lower-level trap already applies, and the syndrome detail it would report.

Some control bits trap when set. Others trap when clear. The code reported depends on both the class and the execution state. Where a vector or matrix operation is caught by both its own control and the floating-point control, its own control wins. Optional features are chosen by parameters. A feature that is absent leaves its bit reading zero and never traps. The control word can be read or written only from level 3. An attempt from a lower level produces an undefined-instruction strobe and leaves the word unchanged.

Top module: `feat_trap_unit`

## Requirements
- R1: Only bits 31, 30, 20, 12, 10 and 8 of the control word are storage. All other bits always read zero, whatever was written to them.
- R2: After reset, the control word equals the CTL_RESET parameter (restricted to implemented bits), and trap_o, undef_o and reg_rdata are zero.
- R3: A read or write is honoured only when cur_lvl is 3. The write takes effect on the clock edge. reg_rdata shows the word one cycle after a read. An attempt at level 0 to 2 raises undef_o one cycle later, returns reg_rdata 0 and leaves the word unchanged.
- R4: Class 1 (control-register access) traps when bit 31 is 1 and lower_trap is 0. With acc_qual=1 (level-2 control register) it traps only from level 2. With acc_qual=0 (level-1 register) it traps from level 1 or 2. The code is 0x03 in 32-bit state and 0x18 in 64-bit state.
- R5: Class 2 (activity monitor) traps when HAS_AMON is set, bit 30 is 1 and the level is 0 to 2. The code is 0x18 in 64-bit state. In 32-bit state it is 0x04 with acc_qual=1 (double-word transfer) and 0x03 otherwise.
- R6: Class 3 (trace register) traps from any level when HAS_TRACE is set, bit 20 is 1 and lower_trap is 0. The code is 0x05 in 32-bit state and 0x18 in 64-bit state.
- R7: Class 4 (matrix), and class 5 with acc_qual=1 (streaming vector), trap when HAS_MATRIX is set and bit 12 is 0. The code is 0x18 for class 4 with acc_qual=1 (priority register). Otherwise it is 0x1D, and the reported ISS is then zero.
- R8: Class 5 with acc_qual=0 (non-streaming vector) traps when HAS_VECTOR is set and bit 8 is 0, with code 0x19.
- R9: Bit 10 set traps class 6 (SIMD/FP), and also classes 4 and 5, with code 0x07.
- R10: When the bit 12 or bit 8 trap applies together with the bit 10 trap, the code comes from bit 12 or bit 8.
- R11: trap_o, trap_ec and trap_iss are registered and appear one cycle after req_valid. All three are zero when no trap fires. trap_iss carries acc_iss unless the code is 0x1D. Class 0 and class 7 never trap.
- R12: A feature parameter that is 0 makes its bit read zero and disables that bit's trap, whatever value is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level |
| is_a32 | input | 1 | 1 = 32-bit execution state |
| reg_wr_en | input | 1 | Write attempt to the control word |
| reg_rd_en | input | 1 | Read attempt of the control word |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after a read |
| undef_o | output | 1 | Undefined-instruction strobe for a lower-level access |
| req_valid | input | 1 | A classified access is presented |
| acc_class | input | 3 | Access class (0 none, 1 ctl-reg, 2 monitor, 3 trace, 4 matrix, 5 vector, 6 SIMD/FP) |
| acc_qual | input | 1 | Per-class qualifier (see requirements) |
| lower_trap | input | 1 | A lower-level control already traps this access |
| acc_iss | input | 25 | Syndrome detail offered by the decoder |
| trap_o | output | 1 | Trap strobe |
| trap_ec | output | 6 | Exception-class code |
| trap_iss | output | 25 | Reported syndrome detail |

## Verification
A control-word write and a trap decision can fall in the same cycle. The decision must then use the value from before the write. The bench provokes this by writing a new configuration in the same cycle as a request whose outcome differs between the old and new values. It checks the old outcome, then repeats the request a cycle later and checks the new one. Every combination of the six control bits is swept against every class, level, state, qualifier and lower-trap value, on one instance with all features and one with none.

// File: rtl/feat_trap_pkg.sv
package feat_trap_pkg;
   localparam int CTL_W = 64;
   localparam int EC_W  = 6;
   localparam int ISS_W = 25;

   // bit positions other logic decodes
   localparam int B_CPAC = 31;
   localparam int B_AMON = 30;
   localparam int B_TRC  = 20;
   localparam int B_MTX  = 12;
   localparam int B_FP   = 10;
   localparam int B_VEC  = 8;

   localparam logic [EC_W-1:0] EC_NONE   = 6'h00;
   localparam logic [EC_W-1:0] EC_MCR32  = 6'h03;
   localparam logic [EC_W-1:0] EC_MCRR32 = 6'h04;
   localparam logic [EC_W-1:0] EC_TRC32  = 6'h05;
   localparam logic [EC_W-1:0] EC_FPU    = 6'h07;
   localparam logic [EC_W-1:0] EC_SYS64  = 6'h18;
   localparam logic [EC_W-1:0] EC_SVEC   = 6'h19;
   localparam logic [EC_W-1:0] EC_MTX    = 6'h1D;

   typedef enum logic [2:0] {
      ACC_NONE = 3'd0,
      ACC_CTL  = 3'd1,
      ACC_AMON = 3'd2,
      ACC_TRC  = 3'd3,
      ACC_MTX  = 3'd4,
      ACC_VEC  = 3'd5,
      ACC_FP   = 3'd6,
      ACC_RSVD = 3'd7
   } acc_cls_e;

   typedef struct packed {
      logic            hit;
      logic [EC_W-1:0] ec;
      logic            zero_iss;
   } trap_dec_t;

   function automatic logic [CTL_W-1:0] impl_mask(input bit amon, input bit trc,
                                                   input bit mtx, input bit vec);
      logic [CTL_W-1:0] m;
      m = '0;
      m[B_CPAC] = 1'b1;
      m[B_FP]   = 1'b1;
      m[B_AMON] = amon;
      m[B_TRC]  = trc;
      m[B_MTX]  = mtx;
      m[B_VEC]  = vec;
      return m;
   endfunction
endpackage

// File: rtl/ftu_ctl_reg.sv
module ftu_ctl_reg
   import feat_trap_pkg::*;
#(
   parameter logic [CTL_W-1:0] MASK      = '0,
   parameter logic [CTL_W-1:0] RST_VALUE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] value
);
   for (genvar b = 0; b < CTL_W; b++) begin : g_bit
      if (MASK[b]) begin : g_store
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= RST_VALUE[b];
            else if (wr_en) q <= wdata[b];
         end
         assign value[b] = q;
      end else begin : g_tie
         assign value[b] = 1'b0;
      end
   end
endmodule

// File: rtl/ftu_decide.sv
module ftu_decide
   import feat_trap_pkg::*;
#(
   parameter bit HAS_AMON   = 1'b1,
   parameter bit HAS_TRACE  = 1'b1,
   parameter bit HAS_MATRIX = 1'b1,
   parameter bit HAS_VECTOR = 1'b1
) (
   input  logic [CTL_W-1:0] ctl,
   input  acc_cls_e         cls,
   input  logic [1:0]       lvl,
   input  logic             a32,
   input  logic             qual,
   input  logic             low_trap,
   output trap_dec_t        dec
);
   logic mtx_on, vec_on, fp_on, lvl_below3;

   assign mtx_on     = HAS_MATRIX && !ctl[B_MTX];   // active low
   assign vec_on     = HAS_VECTOR && !ctl[B_VEC];   // active low
   assign fp_on      = ctl[B_FP];
   assign lvl_below3 = (lvl != 2'd3);

   always_comb begin
      dec = '{hit: 1'b0, ec: EC_NONE, zero_iss: 1'b0};
      case (cls)
         ACC_CTL: begin
            if (ctl[B_CPAC] && !low_trap &&
                (qual ? (lvl == 2'd2) : (lvl == 2'd1 || lvl == 2'd2))) begin
               dec.hit = 1'b1;
               dec.ec  = a32 ? EC_MCR32 : EC_SYS64;
            end
         end
         ACC_AMON: begin
            if (HAS_AMON && ctl[B_AMON] && lvl_below3) begin
               dec.hit = 1'b1;
               dec.ec  = !a32 ? EC_SYS64 : (qual ? EC_MCRR32 : EC_MCR32);
            end
         end
         ACC_TRC: begin
            if (HAS_TRACE && ctl[B_TRC] && !low_trap) begin
               dec.hit = 1'b1;
               dec.ec  = a32 ? EC_TRC32 : EC_SYS64;
            end
         end
         ACC_MTX: begin
            if (mtx_on) begin
               dec.hit      = 1'b1;
               dec.ec       = qual ? EC_SYS64 : EC_MTX;
               dec.zero_iss = !qual;
            end else if (fp_on) begin
               dec.hit = 1'b1;
               dec.ec  = EC_FPU;
            end
         end
         ACC_VEC: begin
            if (qual && mtx_on) begin
               dec.hit      = 1'b1;
               dec.ec       = EC_MTX;
               dec.zero_iss = 1'b1;
            end else if (!qual && vec_on) begin
               dec.hit = 1'b1;
               dec.ec  = EC_SVEC;
            end else if (fp_on) begin
               dec.hit = 1'b1;
               dec.ec  = EC_FPU;
            end
         end
         ACC_FP: begin
            if (fp_on) begin
               dec.hit = 1'b1;
               dec.ec  = EC_FPU;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ftu_out_stage.sv
module ftu_out_stage
   import feat_trap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  trap_dec_t        dec,
   input  logic [ISS_W-1:0] iss_in,
   input  logic             rd_ok,
   input  logic             acc_bad,
   input  logic [CTL_W-1:0] ctl,
   output logic             trap_o,
   output logic [EC_W-1:0]  trap_ec,
   output logic [ISS_W-1:0] trap_iss,
   output logic             undef_o,
   output logic [CTL_W-1:0] rdata
);
   logic fire;
   assign fire = req_valid && dec.hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_o   <= 1'b0;
         trap_ec  <= '0;
         trap_iss <= '0;
         undef_o  <= 1'b0;
         rdata    <= '0;
      end else begin
         trap_o   <= fire;
         trap_ec  <= fire ? dec.ec : '0;
         trap_iss <= (fire && !dec.zero_iss) ? iss_in : '0;
         undef_o  <= acc_bad;
         rdata    <= rd_ok ? ctl : '0;
      end
   end
endmodule

// File: rtl/feat_trap_unit.sv
module feat_trap_unit
   import feat_trap_pkg::*;
#(
   parameter bit               HAS_AMON   = 1'b1,
   parameter bit               HAS_TRACE  = 1'b1,
   parameter bit               HAS_MATRIX = 1'b1,
   parameter bit               HAS_VECTOR = 1'b1,
   parameter logic [CTL_W-1:0] CTL_RESET  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cur_lvl,
   input  logic             is_a32,
   input  logic             reg_wr_en,
   input  logic             reg_rd_en,
   input  logic [CTL_W-1:0] reg_wdata,
   output logic [CTL_W-1:0] reg_rdata,
   output logic             undef_o,
   input  logic             req_valid,
   input  logic [2:0]       acc_class,
   input  logic             acc_qual,
   input  logic             lower_trap,
   input  logic [ISS_W-1:0] acc_iss,
   output logic             trap_o,
   output logic [EC_W-1:0]  trap_ec,
   output logic [ISS_W-1:0] trap_iss
);
   localparam logic [CTL_W-1:0] IMPL_MASK =
      impl_mask(HAS_AMON, HAS_TRACE, HAS_MATRIX, HAS_VECTOR);

   if ((CTL_RESET & ~IMPL_MASK) != '0) begin : g_bad_reset
      $error("CTL_RESET sets bits that are not implemented");
   end

   logic             at_top, wr_ok, rd_ok, acc_bad;
   logic [CTL_W-1:0] ctl;
   trap_dec_t        dec;

   assign at_top  = (cur_lvl == 2'd3);
   assign wr_ok   = reg_wr_en && at_top;
   assign rd_ok   = reg_rd_en && at_top;
   assign acc_bad = (reg_wr_en || reg_rd_en) && !at_top;

   ftu_ctl_reg #(.MASK(IMPL_MASK), .RST_VALUE(CTL_RESET)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wdata(reg_wdata), .value(ctl)
   );

   ftu_decide #(
      .HAS_AMON(HAS_AMON), .HAS_TRACE(HAS_TRACE),
      .HAS_MATRIX(HAS_MATRIX), .HAS_VECTOR(HAS_VECTOR)
   ) u_dec (
      .ctl(ctl), .cls(acc_cls_e'(acc_class)), .lvl(cur_lvl), .a32(is_a32),
      .qual(acc_qual), .low_trap(lower_trap), .dec(dec)
   );

   ftu_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dec(dec),
      .iss_in(acc_iss), .rd_ok(rd_ok), .acc_bad(acc_bad), .ctl(ctl),
      .trap_o(trap_o), .trap_ec(trap_ec), .trap_iss(trap_iss),
      .undef_o(undef_o), .rdata(reg_rdata)
   );
endmodule

// File: rtl/feat_trap_unit_chk.sv
module feat_trap_unit_chk
   import feat_trap_pkg::*;
#(
   parameter logic [CTL_W-1:0] IMPL_MASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cur_lvl,
   input logic             reg_wr_en,
   input logic             reg_rd_en,
   input logic [CTL_W-1:0] reg_rdata,
   input logic             undef_o,
   input logic             req_valid,
   input logic [2:0]       acc_class,
   input logic             acc_qual,
   input logic             trap_o,
   input logic [EC_W-1:0]  trap_ec,
   input logic [ISS_W-1:0] trap_iss
);
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~IMPL_MASK) == '0);

   a_r3_undef_lower: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr_en || reg_rd_en) && cur_lvl != 2'd3) |=> undef_o);

   a_r3_rdata_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && cur_lvl != 2'd3) |=> reg_rdata == '0);

   a_r11_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> (trap_ec == '0 && trap_iss == '0));

   a_r11_no_req_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !trap_o);

   a_r7_mtx_iss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && trap_ec == EC_MTX) |-> trap_iss == '0);

   a_r8_vec_code_source: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && trap_ec != EC_SVEC) ##1 (trap_o && trap_ec == EC_SVEC)
      |-> ($past(acc_class) == 3'd5 && !$past(acc_qual)));
endmodule

bind feat_trap_unit feat_trap_unit_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .reg_wr_en(reg_wr_en),
   .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .undef_o(undef_o),
   .req_valid(req_valid), .acc_class(acc_class), .acc_qual(acc_qual),
   .trap_o(trap_o), .trap_ec(trap_ec), .trap_iss(trap_iss)
);

// File: tb/feat_trap_unit_tb_top.sv
module feat_trap_unit_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [63:0] MIN_RESET = 64'h0000_0000_0000_0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cur_lvl = 2'd3;
   logic        is_a32 = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  acc_class = '0;
   logic        acc_qual = 1'b0, lower_trap = 1'b0;
   logic [24:0] acc_iss = '0;

   logic [63:0] rd_f, rd_m;
   logic        ud_f, ud_m, tr_f, tr_m;
   logic [5:0]  ec_f, ec_m;
   logic [24:0] is_f, is_m;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   feat_trap_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .is_a32(is_a32),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata),
      .reg_rdata(rd_f), .undef_o(ud_f), .req_valid(req_valid),
      .acc_class(acc_class), .acc_qual(acc_qual), .lower_trap(lower_trap),
      .acc_iss(acc_iss), .trap_o(tr_f), .trap_ec(ec_f), .trap_iss(is_f));

   feat_trap_unit #(.HAS_AMON(1'b0), .HAS_TRACE(1'b0), .HAS_MATRIX(1'b0),
                    .HAS_VECTOR(1'b0), .CTL_RESET(MIN_RESET)) dut_min_i (
      .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .is_a32(is_a32),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata),
      .reg_rdata(rd_m), .undef_o(ud_m), .req_valid(req_valid),
      .acc_class(acc_class), .acc_qual(acc_qual), .lower_trap(lower_trap),
      .acc_iss(acc_iss), .trap_o(tr_m), .trap_ec(ec_m), .trap_iss(is_m));

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [63:0] mask_of(input bit full);
      logic [63:0] m = '0;
      m[31] = 1'b1; m[10] = 1'b1;
      if (full) begin m[30] = 1'b1; m[20] = 1'b1; m[12] = 1'b1; m[8] = 1'b1; end
      return m;
   endfunction

   function automatic logic [63:0] spread(input int cfg);
      logic [63:0] v = '0;
      v[31] = cfg[0]; v[30] = cfg[1]; v[20] = cfg[2];
      v[12] = cfg[3]; v[10] = cfg[4]; v[8]  = cfg[5];
      return v;
   endfunction

   // expected {hit, ec} from the requirements
   function automatic logic [6:0] model(input logic [63:0] c, input bit full,
         input int cls, input int lvl, input bit a32, input bit q, input bit low);
      bit mtx = full && !c[12];
      bit vec = full && !c[8];
      bit fp  = c[10];
      case (cls)
         1: if (c[31] && !low && (q ? lvl == 2 : (lvl == 1 || lvl == 2)))
               return {1'b1, a32 ? 6'h03 : 6'h18};
         2: if (full && c[30] && lvl < 3)
               return {1'b1, !a32 ? 6'h18 : (q ? 6'h04 : 6'h03)};
         3: if (full && c[20] && !low) return {1'b1, a32 ? 6'h05 : 6'h18};
         4: if (mtx) return {1'b1, q ? 6'h18 : 6'h1D};
            else if (fp) return {1'b1, 6'h07};
         5: if (q && mtx) return {1'b1, 6'h1D};
            else if (!q && vec) return {1'b1, 6'h19};
            else if (fp) return {1'b1, 6'h07};
         6: if (fp) return {1'b1, 6'h07};
         default: ;
      endcase
      return 7'd0;
   endfunction

   function automatic string req_of(input int cls, input logic [6:0] e);
      if (e[5:0] == 6'h07 && (cls == 4 || cls == 5)) return "R10/R9";
      case (cls)
         1: return "R4"; 2: return "R5"; 3: return "R6"; 4: return "R7";
         5: return (e[5:0] == 6'h1D) ? "R7" : "R8"; 6: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic reg_access(input bit wr, input logic [63:0] d, input logic [1:0] lvl);
      cur_lvl = lvl; reg_wr_en = wr; reg_rd_en = !wr; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_rd_en = 1'b0;
   endtask

   task automatic judge(input logic [63:0] cf, input logic [63:0] cm, input int cls,
         input int lvl, input bit a32, input bit q, input bit low, input logic [24:0] iss);
      logic [6:0] ef = model(cf, 1'b1, cls, lvl, a32, q, low);
      logic [6:0] em = model(cm, 1'b0, cls, lvl, a32, q, low);
      logic [24:0] xf = (ef[6] && ef[5:0] != 6'h1D) ? iss : '0;
      logic [24:0] xm = (em[6] && em[5:0] != 6'h1D) ? iss : '0;
      check({req_of(cls, ef), " full strobe+ec"}, {57'd0, tr_f, ec_f}, {57'd0, ef});
      check("R11 full iss", {39'd0, is_f}, {39'd0, xf});
      check({req_of(cls, em), " R12 min strobe+ec"}, {57'd0, tr_m, ec_m}, {57'd0, em});
      check("R11 R12 min iss", {39'd0, is_m}, {39'd0, xm});
   endtask

   initial begin
      for (int n = 0; n < 200000; n++) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] cur_f, cur_m, junk;
      repeat (3) @(negedge clk);
      check("R2 trap after reset", {63'd0, tr_f | tr_m | ud_f | ud_m}, 64'd0);
      check("R2 rdata after reset", rd_f | rd_m, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_access(1'b0, '0, 2'd3);
      check("R2 full reset value", rd_f, 64'd0);
      check("R2 min reset value", rd_m, MIN_RESET);

      // R1: all-ones write reads back the implemented bits only
      reg_access(1'b1, '1, 2'd3);
      reg_access(1'b0, '0, 2'd3);
      check("R1 full readback", rd_f, mask_of(1'b1));
      check("R12 min readback", rd_m, mask_of(1'b0));

      // R3: lower-level attempts are refused
      for (int l = 0; l < 3; l++) begin
         reg_access(1'b1, '0, 2'(l));
         check("R3 undef on write", {62'd0, ud_f, ud_m}, 64'd3);
         reg_access(1'b0, '0, 2'(l));
         check("R3 undef on read", {62'd0, ud_f, ud_m}, 64'd3);
         check("R3 rdata zero", rd_f | rd_m, 64'd0);
      end
      reg_access(1'b0, '0, 2'd3);
      check("R3 write ignored full", rd_f, mask_of(1'b1));
      check("R3 undef absent at top", {63'd0, ud_f}, 64'd0);

      // exhaustive sweep
      junk = ~mask_of(1'b1);
      for (int cfg = 0; cfg < 64; cfg++) begin
         cur_f = spread(cfg);
         cur_m = cur_f & mask_of(1'b0);
         reg_access(1'b1, cur_f | junk, 2'd3);
         reg_access(1'b0, '0, 2'd3);
         check("R1 sweep readback", rd_f, cur_f);
         check("R12 sweep readback", rd_m, cur_m);
         for (int cls = 0; cls < 8; cls++)
            for (int l = 0; l < 4; l++)
               for (int s = 0; s < 2; s++)
                  for (int q = 0; q < 2; q++)
                     for (int low = 0; low < 2; low++) begin
                        logic [24:0] iss = 25'h0A5_5A3 ^ 25'(cfg * 97 + cls * 13 + l);
                        cur_lvl = 2'(l); is_a32 = s[0]; acc_qual = q[0];
                        lower_trap = low[0]; acc_class = 3'(cls);
                        acc_iss = iss; req_valid = 1'b1;
                        @(negedge clk);
                        judge(cur_f, cur_m, cls, l, s[0], q[0], low[0], iss);
                     end
         req_valid = 1'b0;
         @(negedge clk);
         check("R11 no request no trap", {63'd0, tr_f | tr_m}, 64'd0);
      end

      // write and decision in the same cycle: old value decides
      reg_access(1'b1, 64'h0, 2'd3);          // FP control off
      cur_lvl = 2'd3; acc_class = 3'd6; req_valid = 1'b1; acc_iss = 25'h123;
      reg_wr_en = 1'b1; reg_wdata = 64'h400;  // turn FP control on
      @(negedge clk);
      reg_wr_en = 1'b0;
      check("R3 R9 decision uses old value", {63'd0, tr_f}, 64'd0);
      @(negedge clk);
      check("R3 R9 decision uses new value", {57'd0, tr_f, ec_f}, {57'd0, 1'b1, 6'h07});
      req_valid = 1'b0;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule